// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Tree Adder

This block adds two unsigned operands and a carry-in in purely combinational logic. Each bit first forms a propagate term (the XOR of its operand bits) and a generate term (their AND). The adder's carry-in is merged into the generate term of bit 0. The per-bit pairs are then combined into group pairs. The rule for combining a higher span with the span just below it is: group propagate is the AND of both propagates, and group generate is the higher generate ORed with the higher propagate ANDed with the lower generate.

The combining runs in two phases. An upward phase pairs neighbouring spans at doubling distances. For eight bits this yields spans 1:0, 3:2, 5:4 and 7:6, then 3:0 and 7:4, and finally 7:0. That phase only gives carries at the tops of spans. A downward fill-in phase therefore combines the remaining positions with the nearest finished prefix below them. After both phases every position k holds the carry out of bits k:0. The sum bit at position i is the bit propagate XORed with that carry out of position i-1, or with the carry-in at position 0. The carry path has about 2·log2(WIDTH)-1 combine levels, so its depth grows with the logarithm of the width. WIDTH is a power of two.

Top module: `prefix_tree_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, taken as unsigned values.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`.
- R3: When every bit position propagates (`a_i ^ b_i` all ones), `cout_o` equals `cin_i`, and every bit of `sum_o` equals the inverse of `cin_i`.
- R4: When both operands have their top bit set, `cout_o` is 1 whatever the other inputs are.
- R5: When both operands have their top bit clear, `cout_o` is 0 whatever the other inputs are.
- R6: A carry generated at the lowest bit (both bit 0 set, `cin_i` = 0), with all bits above it propagating, reaches every higher position. The result is `sum_o` = 0 with `cout_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The assertions are evaluated whenever the inputs change. They check the full arithmetic result, and the full-propagate, top-generate and top-kill relations, on every input value applied. The bench alone shows that the design gives correct results over the whole input space at the default width, by sweeping every combination of both operands and the carry-in. Its directed cases confirm that a carry born at bit 0 travels the full length through the fill-in nodes.

// File: rtl/prefix_tree_adder.sv
module prefix_tree_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int LVL = $clog2(WIDTH);
  localparam int NST = 2 * LVL;

  logic [WIDTH-1:0] bp, bg;
  logic [NST-1:0][WIDTH-1:0] tp, tg;
  logic [WIDTH-1:0] cy;

  assign bp = a_i ^ b_i;
  assign bg = a_i & b_i;

  assign tp[0] = bp;
  assign tg[0] = {bg[WIDTH-1:1], bg[0] | (bp[0] & cin_i)};

  for (genvar s = 1; s < NST; s++) begin : g_stage
    localparam int UP = (s <= LVL);
    localparam int D  = UP ? (1 << (s - 1)) : (1 << (NST - s - 1));
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      localparam bit ACT = UP ? (((k + 1) % (2 * D)) == 0)
                              : ((((k + 1) % (2 * D)) == D) && (k >= 3 * D - 1));
      if (ACT) begin : g_node
        assign tp[s][k] = tp[s-1][k] & tp[s-1][k-D];
        assign tg[s][k] = tg[s-1][k] | (tp[s-1][k] & tg[s-1][k-D]);
      end else begin : g_pass
        assign tp[s][k] = tp[s-1][k];
        assign tg[s][k] = tg[s-1][k];
      end
    end
  end

  assign cy     = {tg[NST-1][WIDTH-2:0], cin_i};
  assign sum_o  = bp ^ cy;
  assign cout_o = tg[NST-1][WIDTH-1];
endmodule

// File: rtl/prefix_tree_adder_chk.sv
module prefix_tree_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    p_sum_r1: assert (sum_o == ref_sum[WIDTH-1:0]) else $error("R1 sum");
    p_cout_r2: assert (cout_o == ref_sum[WIDTH]) else $error("R2 carry");
    if ((a_i ^ b_i) == {WIDTH{1'b1}})
      p_prop_r3: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}}) else $error("R3 propagate");
    if (a_i[WIDTH-1] && b_i[WIDTH-1])
      p_gen_r4: assert (cout_o) else $error("R4 generate");
    if (!a_i[WIDTH-1] && !b_i[WIDTH-1])
      p_kill_r5: assert (!cout_o) else $error("R5 kill");
  end
endmodule

bind prefix_tree_adder prefix_tree_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/prefix_tree_adder_tb.sv
module prefix_tree_adder_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic cin, cout;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefix_tree_adder #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d cin=%0d got=%0h exp=%0h", req, a, b, cin, got, exp);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    for (int x = 0; x < (1 << W); x++)
      for (int y = 0; y < (1 << W); y++)
        for (int c = 0; c < 2; c++) begin
          apply(W'(x), W'(y), 1'(c));
          check("R1/R2 sweep", {cout, sum}, (W+1)'(x + y + c));
        end
    // R3: all propagate, carry-in passes through every bit
    apply(8'hA5, 8'h5A, 1'b1); check("R3 cin=1", {cout, sum}, 9'h100);
    apply(8'hF0, 8'h0F, 1'b0); check("R3 cin=0", {cout, sum}, 9'h0FF);
    // R4: top generate forces carry-out
    apply(8'h80, 8'h80, 1'b0); check("R4 top gen", {cout, sum}, 9'h100);
    apply(8'hC1, 8'h82, 1'b1); check("R4 top gen mixed", {cout, sum}, 9'h144);
    // R5: top kill blocks carry-out
    apply(8'h7F, 8'h7F, 1'b1); check("R5 top kill", {cout, sum}, 9'h0FF);
    apply(8'h00, 8'h00, 1'b1); check("R5 zero", {cout, sum}, 9'h001);
    // R6: carry generated at bit 0 travels to the top
    apply(8'hFF, 8'h01, 1'b0); check("R6 long carry", {cout, sum}, 9'h100);
    apply(8'h01, 8'hFF, 1'b0); check("R6 long carry swap", {cout, sum}, 9'h100);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule